// File: doc/BRIEF.md
# Processor Timer Mode Mask Register

This block is the mode-select register that lives in the system-wide timer. It holds one mode bit for each of up to 16 processor-local timers. A clear bit keeps that timer in limit mode: it counts up to a programmed limit and raises an interrupt. A set bit turns the timer into a free-running counter for user software, and that counter never interrupts. The mask bits drive the mode inputs of the timers directly.

Software reaches the block through a plain word-indexed register port. A write to the mode register index replaces the whole mask in one step, so a single write can move any number of timers between the two modes at once. In the cycle after the write, the block sends two one-cycle pulses to the timers:

- A restart pulse goes to every timer whose bit changed. The timer stops, reloads and counts again from zero.
- An interrupt-clear pulse goes to every timer whose bit is set in the written value. That timer drops any pending interrupt and loads its maximum limit.

A read returns the current mask one cycle after the request. The port has no flow control: requests are accepted every cycle, so there is no valid/ready back-pressure.

Top module: `tmc_mode_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the mask is all zeros, so every timer is in limit mode. In the same period, no restart or interrupt-clear pulse is high and `rd_valid` is low.
- R2: A write with `reg_addr` equal to 4 (the mode register index) loads `reg_wdata[15:0]` into the mask. `tmr_user_mode` shows the new mask from the cycle after the write. Bits 31..16 of the written word are discarded.
- R3: In the cycle after a mode write, `tmr_restart[i]` is 1 exactly for each bit i where the written bit differs from the previous mask bit.
- R4: In the cycle after a mode write, `tmr_irq_clr[i]` equals bit i of the written value, whether or not that bit changed.
- R5: `tmr_restart` and `tmr_irq_clr` are all zero in every cycle that does not directly follow an accepted mode write, so each pulse lasts exactly one cycle.
- R6: A write to any index other than 4 leaves the mask unchanged and produces no pulses.
- R7: A read request raises `rd_valid` in the next cycle. For index 4 it returns the mask, zero-extended to 32 bits. When a read and a mode write arrive in the same cycle, the read returns the mask value from before the write.
- R8: A read of any index other than 4 returns zero with `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write request this cycle |
| reg_rd | input | 1 | Read request this cycle |
| reg_addr | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `reg_rd` |
| rd_data | output | 32 | Read data |
| tmr_user_mode | output | 16 | Mode bit per timer (1 = free-running user mode) |
| tmr_restart | output | 16 | One-cycle restart pulse per timer |
| tmr_irq_clr | output | 16 | One-cycle interrupt-clear pulse per timer |

## Verification
The bench builds the block with its defaults: 16 timers, a 32-bit data word, a 3-bit word index and the mode register at index 4.

With these values, every mask bit can be reached by random writes. Words with nonzero upper bits test that bits 31..16 are discarded, and the other seven indices show that their writes are ignored and their reads return zero. Directed cases cover:

- all bits flipping at once;
- rewriting the same mask, so interrupt-clear pulses appear with no restart;
- a read and a write in the same cycle.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int unsigned TMC_MODE_IDX_DEF = 4;
  localparam int unsigned TMC_TIMERS_DEF   = 16;

  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
    logic rd_any;
  } tmc_access_t;
endpackage

// File: rtl/tmc_access_decode.sv
module tmc_access_decode #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned MODE_IDX = 4
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output tmc_pkg::tmc_access_t acc
);
  localparam logic [ADDR_W-1:0] IDX = ADDR_W'(MODE_IDX);

  always_comb begin
    acc.wr_hit = wr && (addr == IDX);
    acc.rd_hit = rd && (addr == IDX);
    acc.rd_any = rd;
  end
endmodule

// File: rtl/tmc_mask_reg.sv
module tmc_mask_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask <= '0;
    else if (load) mask <= load_val;
  end
endmodule

// File: rtl/tmc_pulse_gen.sv
module tmc_pulse_gen #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [N-1:0] old_mask,
  input  logic [N-1:0] new_mask,
  output logic [N-1:0] restart,
  output logic [N-1:0] irq_clr
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        restart[i] <= 1'b0;
        irq_clr[i] <= 1'b0;
      end else begin
        restart[i] <= fire && (old_mask[i] != new_mask[i]);
        irq_clr[i] <= fire && new_mask[i];
      end
    end
  end
endmodule

// File: rtl/tmc_read_port.sv
module tmc_read_port #(
  parameter int unsigned N      = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmc_pkg::tmc_access_t acc,
  input  logic [N-1:0]      mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc.rd_any;
      if (acc.rd_any) rd_data <= acc.rd_hit ? DATA_W'(mask) : '0;
    end
  end
endmodule

// File: rtl/tmc_mode_ctrl.sv
module tmc_mode_ctrl #(
  parameter int unsigned N_TIMERS = tmc_pkg::TMC_TIMERS_DEF,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned MODE_IDX = tmc_pkg::TMC_MODE_IDX_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [N_TIMERS-1:0] tmr_user_mode,
  output logic [N_TIMERS-1:0] tmr_restart,
  output logic [N_TIMERS-1:0] tmr_irq_clr
);
  tmc_pkg::tmc_access_t acc;
  logic [N_TIMERS-1:0]  new_mask;

  assign new_mask = reg_wdata[N_TIMERS-1:0];

  if (DATA_W > N_TIMERS) begin : g_hi
    logic unused_hi_bits;
    assign unused_hi_bits = ^reg_wdata[DATA_W-1:N_TIMERS];
  end

  tmc_access_decode #(.ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)) u_dec (
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .acc(acc)
  );

  tmc_mask_reg #(.N(N_TIMERS)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(acc.wr_hit), .load_val(new_mask),
    .mask(tmr_user_mode)
  );

  tmc_pulse_gen #(.N(N_TIMERS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(acc.wr_hit), .old_mask(tmr_user_mode),
    .new_mask(new_mask), .restart(tmr_restart), .irq_clr(tmr_irq_clr)
  );

  tmc_read_port #(.N(N_TIMERS), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .acc(acc), .mask(tmr_user_mode),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/tmc_mode_ctrl_chk.sv
module tmc_mode_ctrl_chk #(
  parameter int unsigned N_TIMERS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned MODE_IDX = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic                rd_valid,
  input logic [DATA_W-1:0]   rd_data,
  input logic [N_TIMERS-1:0] tmr_user_mode,
  input logic [N_TIMERS-1:0] tmr_restart,
  input logic [N_TIMERS-1:0] tmr_irq_clr
);
  logic hit;
  assign hit = reg_wr && (reg_addr == ADDR_W'(MODE_IDX));

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (tmr_user_mode == '0 && tmr_restart == '0 && tmr_irq_clr == '0 && !rd_valid)); // R1
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> tmr_user_mode == $past(reg_wdata[N_TIMERS-1:0])); // R2
  AST_RESTART_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> tmr_restart == ($past(reg_wdata[N_TIMERS-1:0]) ^ $past(tmr_user_mode))); // R3
  AST_CLEAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> tmr_irq_clr == $past(reg_wdata[N_TIMERS-1:0])); // R4
  AST_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (tmr_restart == '0 && tmr_irq_clr == '0)); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(tmr_user_mode)); // R6
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid); // R7
  AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != ADDR_W'(MODE_IDX)) |=> rd_data == '0); // R8
endmodule

bind tmc_mode_ctrl tmc_mode_ctrl_chk #(
  .N_TIMERS(N_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)
) u_chk (.*);

// File: tb/sim_tmc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_tmc_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] tmr_user_mode, tmr_restart, tmr_irq_clr;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_mask = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmc_mode_ctrl u0 (.*);

  function automatic logic [15:0] f_restart(input logic [15:0] old_m, input logic [31:0] d);
    return old_m ^ d[15:0];
  endfunction
  function automatic logic [31:0] f_read(input logic [2:0] a, input logic [15:0] m);
    return (a == 3'd4) ? {16'h0, m} : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Write, then check pulses and mask in the next cycle, and quiet pulses after.
  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    logic [15:0] old_m = exp_mask;
    bit hit = (a == 3'd4);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    if (hit) exp_mask = d[15:0];
    check(hit ? "R2 mask load" : "R6 mask hold", 32'(tmr_user_mode), 32'(exp_mask));
    check("R3 restart", 32'(tmr_restart), hit ? 32'(f_restart(old_m, d)) : 32'h0);
    check(hit ? "R4 irq clear" : "R6 no clear", 32'(tmr_irq_clr), hit ? 32'(d[15:0]) : 32'h0);
    @(negedge clk); reg_wr = 0;
    @(posedge clk); #1;
    check("R5 pulses end", {tmr_restart, tmr_irq_clr}, 32'h0);
  endtask

  task automatic do_read(input logic [2:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(posedge clk); #1;
    check("R7 rd_valid", 32'(rd_valid), 32'h1);
    check(a == 3'd4 ? "R7 read mask" : "R8 read other", rd_data, f_read(a, exp_mask));
    @(negedge clk); reg_rd = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset mask", 32'(tmr_user_mode), 32'h0);
    check("R1 reset pulses", {tmr_restart, tmr_irq_clr}, 32'h0);
    check("R1 reset rd_valid", 32'(rd_valid), 32'h0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 after reset", {tmr_user_mode, tmr_restart}, 32'h0);

    // Directed corners
    do_write(3'd4, 32'hFFFF_FFFF);   // all flip, upper bits dropped
    do_write(3'd4, 32'h0000_FFFF);   // same mask: clears, no restart
    do_write(3'd4, 32'hABCD_0000);   // all flip back to zero
    do_write(3'd2, 32'h0000_1234);   // other index ignored, R6
    do_read(3'd4);
    do_read(3'd3);                   // R8

    // Same-cycle read and write: read returns old mask (R7)
    @(negedge clk); reg_wr = 1; reg_rd = 1; reg_addr = 3'd4; reg_wdata = 32'h0000_5A5A;
    @(posedge clk); #1;
    check("R7 old value on collision", rd_data, f_read(3'd4, exp_mask));
    exp_mask = 16'h5A5A;
    check("R2 collision write", 32'(tmr_user_mode), 32'(exp_mask));
    @(negedge clk); reg_wr = 0; reg_rd = 0;

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [2:0] a = ($urandom % 4 == 0) ? 3'($urandom) : 3'd4;
      if ($urandom % 3 == 0) do_read(a);
      else do_write(a, $urandom);
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule